// File: doc/BRIEF.md
# Dual-Mode Processor Bus Register Slave

This block connects an external 8-bit processor to an internal register file. The processor uses asynchronous bus timing. A static mode input chooses one of two conventions on the same pins. In Intel style there is a separate read strobe and a separate write strobe. In Motorola style there is one data strobe and a read/write direction line. Every bus input is synchronised to the system clock, and all decoding runs in that clock domain.

The address arrives on a 12-bit bus. It is held only when the address strobe returns high while the chip is selected. The register side sees one address, a one-clock write-enable pulse with its data, and a combinational read-data return. The 8-bit data bus is split into an input, an output and an output enable, for a pad cell outside the block. A ready output tells the processor when the current access may finish.

Top module: `mpu_bus_slave`

## Requirements
- R1: `motoMode` high selects Motorola style, where `stbA` is the active-low data strobe and `stbB` is direction (1 = read, 0 = write). Low selects Intel style, where `stbA` is the active-low read strobe and `stbB` the active-low write strobe. In Motorola style a low `stbB` with `stbA` high starts no access.
- R2: When `asN` goes from low to high while `csN` is low, `addrIn` is latched and then appears on `regAddr`. `regAddr` holds that value until the next such edge.
- R3: While `csN` is high, every strobe is ignored. No address is latched, no write pulse is produced, `dataOe` stays low and `ready` stays low.
- R4: In Intel style, each low-to-high transition of the write strobe produces exactly one `regWe` pulse. The pulse carries the latched address and the data last seen on `dataIn` while the strobe was low.
- R5: In Motorola style, the data strobe returning high after a low period with direction low produces exactly one `regWe` pulse with the latched address and captured data.
- R6: In Motorola style, a data strobe low with direction high is a read. It drives `dataOut` with `regRdata` for the latched address and produces no write pulse.
- R7: In Intel style, a low read strobe drives `dataOut` with `regRdata` for the latched address.
- R8: `dataOe` is high only during a synchronised read access, meaning chip select low, read indicated and the read or data strobe low. It is low at all other times, including during writes.
- R9: `ready` is high from the fifth rising clock edge after the active strobe pin falls. That is two synchroniser flops, one detection edge and two delay clocks. `ready` is low again from the third rising edge after the strobe returns high.
- R10: Each `regWe` pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| motoMode | input | 1 | Bus convention select, 1 = Motorola style |
| csN | input | 1 | Active-low chip select |
| asN | input | 1 | Active-low address strobe, address latched on its rising edge |
| addrIn | input | 12 | Processor address bus |
| stbA | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| stbB | input | 1 | Write strobe (Intel, active low) or direction (Motorola, 1 = read) |
| dataIn | input | 8 | Data bus input from the pad |
| dataOut | output | 8 | Data bus output to the pad |
| dataOe | output | 1 | Data bus output enable |
| ready | output | 1 | Access may complete |
| regAddr | output | 12 | Latched register address |
| regWe | output | 1 | One-clock register write enable |
| regWdata | output | 8 | Register write data |
| regRdata | input | 8 | Register read data for `regAddr` |

## Verification
Some properties are checked on every clock against the synchronised pin levels:
- a write pulse lasts one clock, follows the end of a synchronised write strobe and never occurs with chip select high;
- the output enable follows only a synchronised read;
- ready rises only after three consecutive active cycles, and drops one clock after the access ends.

Other behaviour can only be shown by the bench's bus scenarios:
- the pin-referenced ready latency;
- correct address and data on each write, in both conventions;
- read data from the latched address;
- the fact that a deselected address strobe leaves the previous address in place.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 8;
  localparam int READY_DELAY = 2;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_WAIT  = 2'd1,
    HS_READY = 2'd2
  } hsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic holdWdata;
    logic commitWr;
    logic driveRd;
  } dpCtl_t;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = mbs_pkg::SYNC_STAGES,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= RESET_VAL;
          else       stage[g] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= RESET_VAL;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int READY_DLY = READY_DELAY
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   modeS,
  input  logic   csS,
  input  logic   asS,
  input  logic   stbAS,
  input  logic   stbBS,
  output dpCtl_t ctl,
  output logic   ready
);
  localparam int CNT_W = (READY_DLY < 2) ? 1 : $clog2(READY_DLY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(READY_DLY - 1);

  logic     asPrev;
  logic     wrPrev;
  logic     rdAct;
  logic     wrAct;
  logic     accAct;
  logic     wrRelease;
  hsState_e state;
  logic [CNT_W-1:0] waitCnt;

  // pin meaning depends on bus convention
  always_comb begin
    if (modeS) begin
      rdAct     = !csS && !stbAS && stbBS;
      wrAct     = !csS && !stbAS && !stbBS;
      wrRelease = stbAS;
    end else begin
      rdAct     = !csS && !stbAS;
      wrAct     = !csS && !stbBS;
      wrRelease = stbBS;
    end
  end

  assign accAct = rdAct || wrAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asPrev <= 1'b1;
      wrPrev <= 1'b0;
    end else begin
      asPrev <= asS;
      wrPrev <= wrAct;
    end
  end

  always_comb begin
    ctl.latchAddr = !csS && asS && !asPrev;
    ctl.holdWdata = wrAct;
    ctl.commitWr  = wrPrev && !wrAct && !csS && wrRelease;
    ctl.driveRd   = rdAct;
  end

  // ready handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= HS_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        HS_IDLE: begin
          if (accAct) begin
            state   <= HS_WAIT;
            waitCnt <= CNT_LOAD;
          end
        end
        HS_WAIT: begin
          if (!accAct)           state <= HS_IDLE;
          else if (waitCnt == 0) state <= HS_READY;
          else                   waitCnt <= waitCnt - 1'b1;
        end
        HS_READY: begin
          if (!accAct) state <= HS_IDLE;
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  assign ready = (state == HS_READY);
endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] addrS,
  input  logic [DW-1:0] dataS,
  input  logic [DW-1:0] regRdata,
  output logic [AW-1:0] regAddr,
  output logic          regWe,
  output logic [DW-1:0] regWdata,
  output logic [DW-1:0] dataOut,
  output logic          dataOe
);
  logic [AW-1:0] addrLatch;
  logic [DW-1:0] wdHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      wdHold    <= '0;
      regWe     <= 1'b0;
      regWdata  <= '0;
      dataOut   <= '0;
      dataOe    <= 1'b0;
    end else begin
      if (ctl.latchAddr) addrLatch <= addrS;
      if (ctl.holdWdata) wdHold <= dataS;
      regWe <= ctl.commitWr;
      if (ctl.commitWr) regWdata <= wdHold;
      dataOe <= ctl.driveRd;
      if (ctl.driveRd) dataOut <= regRdata;
    end
  end

  assign regAddr = addrLatch;
endmodule

// File: rtl/mpu_bus_slave.sv
module mpu_bus_slave
  import mbs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          motoMode,
  input  logic          csN,
  input  logic          asN,
  input  logic [AW-1:0] addrIn,
  input  logic          stbA,
  input  logic          stbB,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic          ready,
  output logic [AW-1:0] regAddr,
  output logic          regWe,
  output logic [DW-1:0] regWdata,
  input  logic [DW-1:0] regRdata
);
  logic          modeS;
  logic          csS;
  logic          asS;
  logic          stbAS;
  logic          stbBS;
  logic [AW-1:0] addrS;
  logic [DW-1:0] dataS;
  dpCtl_t        ctl;

  mbs_sync #(.WIDTH(5), .RESET_VAL(5'b01111)) u_syncPins (
    .clk(clk), .rstN(rstN),
    .asyncIn({motoMode, csN, asN, stbA, stbB}),
    .syncOut({modeS, csS, asS, stbAS, stbBS})
  );

  mbs_sync #(.WIDTH(AW)) u_syncAddr (
    .clk(clk), .rstN(rstN), .asyncIn(addrIn), .syncOut(addrS)
  );

  mbs_sync #(.WIDTH(DW)) u_syncData (
    .clk(clk), .rstN(rstN), .asyncIn(dataIn), .syncOut(dataS)
  );

  mbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeS(modeS), .csS(csS), .asS(asS), .stbAS(stbAS), .stbBS(stbBS),
    .ctl(ctl), .ready(ready)
  );

  mbs_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .addrS(addrS), .dataS(dataS), .regRdata(regRdata),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rstN,
  input logic modeS,
  input logic csS,
  input logic stbAS,
  input logic stbBS,
  input logic ready,
  input logic regWe,
  input logic dataOe
);
  logic rdSeen;
  logic wrSeen;

  assign rdSeen = !csS && !stbAS && (modeS ? stbBS : 1'b1);
  assign wrSeen = !csS && (modeS ? (!stbAS && !stbBS) : !stbBS);

  // R10
  we_one_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R4
  we_after_strobe_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> ($past(wrSeen, 2) && !$past(wrSeen, 1)));

  // R3
  we_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !$past(csS, 1));

  // R8
  oe_only_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(rdSeen, 1));

  // R9
  ready_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(rdSeen || wrSeen, 1) && $past(rdSeen || wrSeen, 2)
                      && $past(rdSeen || wrSeen, 3)));

  // R9
  ready_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !(rdSeen || wrSeen)) |=> !ready);
endmodule

bind mpu_bus_slave mbs_checker u_chk (
  .clk(clk), .rstN(rstN), .modeS(modeS), .csS(csS),
  .stbAS(stbAS), .stbBS(stbBS), .ready(ready), .regWe(regWe), .dataOe(dataOe)
);

// File: tb/mpu_bus_slave_tb.sv
module mpu_bus_slave_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        motoMode = 1'b0;
  logic        csN = 1'b1;
  logic        asN = 1'b1;
  logic [11:0] addrIn = '0;
  logic        stbA = 1'b1;
  logic        stbB = 1'b1;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        ready;
  logic [11:0] regAddr;
  logic        regWe;
  logic [7:0]  regWdata;
  logic [7:0]  regRdata;

  int errors = 0;
  int checks = 0;
  int writesSeen = 0;
  bit finished = 1'b0;
  logic wePrev = 1'b0;
  logic [19:0] expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;

  function automatic logic [7:0] regModel(input logic [11:0] a);
    return {a[3:0], a[11:8]} ^ 8'h3C;
  endfunction

  assign regRdata = regModel(regAddr);

  mpu_bus_slave u_dut (
    .clk(clk), .rstN(rstN), .motoMode(motoMode), .csN(csN), .asN(asN),
    .addrIn(addrIn), .stbA(stbA), .stbB(stbB), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .ready(ready), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for write pulses
  always @(negedge clk) begin
    if (rstN) begin
      if (regWe) begin
        writesSeen++;
        chk(!wePrev, "R10", "write pulse longer than one clock", 1, 0);
        if (expQ.size() == 0) begin
          chk(1'b0, "R3", "unexpected write pulse", {regAddr, regWdata}, 0);
        end else begin
          logic [19:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({regAddr, regWdata} == e, t, "write address/data",
              {regAddr, regWdata}, e);
        end
      end
      wePrev <= regWe;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendAddr(input logic [11:0] a);
    asN = 1'b0; addrIn = a;
    idle(4);
    asN = 1'b1;
    idle(4);
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [7:0] d, input string t);
    csN = 1'b0;
    sendAddr(a);
    dataIn = d;
    expQ.push_back({a, d});
    tagQ.push_back(t);
    if (motoMode) begin stbB = 1'b0; idle(1); stbA = 1'b0; end
    else stbB = 1'b0;
    idle(6);
    chk(dataOe == 1'b0, "R8", "output enable during write", dataOe, 0);
    if (motoMode) begin stbA = 1'b1; idle(1); stbB = 1'b1; end
    else stbB = 1'b1;
    idle(6);
    csN = 1'b1;
    idle(3);
  endtask

  task automatic doRead(input logic [11:0] a, input bit newAddr, input string t);
    csN = 1'b0;
    if (newAddr) sendAddr(a);
    stbA = 1'b0;
    idle(4);
    chk(ready == 1'b0, "R9", "ready before fifth edge", ready, 0);
    idle(1);
    chk(ready == 1'b1, "R9", "ready at fifth edge", ready, 1);
    chk(dataOe == 1'b1, t, "output enable during read", dataOe, 1);
    chk(dataOut == regModel(a), t, "read data", dataOut, regModel(a));
    chk(regAddr == a, "R2", "latched address", regAddr, a);
    stbA = 1'b1;
    idle(2);
    chk(ready == 1'b1, "R9", "ready held until third edge", ready, 1);
    idle(1);
    chk(ready == 1'b0, "R9", "ready released", ready, 0);
    chk(dataOe == 1'b0, "R8", "output enable released", dataOe, 0);
    csN = 1'b1;
    idle(3);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    chk(ready == 1'b0, "R9", "ready after reset", ready, 0);
    chk(dataOe == 1'b0, "R8", "oe after reset", dataOe, 0);
    chk(regWe == 1'b0, "R10", "write after reset", regWe, 0);

    // Intel style
    motoMode = 1'b0;
    idle(4);
    doWrite(12'h1A5, 8'h5E, "R4");
    doWrite(12'hFFF, 8'h00, "R4");
    doWrite(12'h000, 8'hFF, "R4");
    doRead(12'h2C3, 1'b1, "R7");
    doRead(12'h8F1, 1'b1, "R7");

    // deselected: everything ignored
    csN = 1'b1;
    sendAddr(12'h777);
    stbB = 1'b0; idle(6); stbB = 1'b1;
    stbA = 1'b0; idle(8);
    chk(ready == 1'b0, "R3", "ready while deselected", ready, 0);
    chk(dataOe == 1'b0, "R3", "oe while deselected", dataOe, 0);
    stbA = 1'b1;
    idle(4);
    chk(regAddr == 12'h8F1, "R3", "address kept while deselected", regAddr, 12'h8F1);
    doRead(12'h8F1, 1'b0, "R3");

    // Motorola style
    motoMode = 1'b1;
    idle(4);
    csN = 1'b0;
    stbB = 1'b0; idle(8);
    chk(ready == 1'b0, "R1", "direction alone starts no access", ready, 0);
    stbB = 1'b1; csN = 1'b1; idle(4);
    doWrite(12'h3B7, 8'hA1, "R5");
    doWrite(12'hC08, 8'h7E, "R5");
    doRead(12'h4D2, 1'b1, "R6");
    doRead(12'hE19, 1'b1, "R6");

    motoMode = 1'b0;
    idle(4);
    doWrite(12'h0F0, 8'h33, "R1");

    idle(6);
    chk(expQ.size() == 0, "R4", "writes still pending", expQ.size(), 0);
    chk(writesSeen == 6, "R5", "write pulse count", writesSeen, 6);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule